// File: doc/BRIEF.md
# Compiler-Scheduled Static Operand Switch

This block is the tile-local switch of a statically scheduled operand network. It moves 32-bit operand words between the four mesh neighbours (north, south, east, west) and the local processor port. No decision is taken by looking at the data. A small program memory, written before the switch is started, holds a sequence of route steps. Each step connects any number of inputs to outputs across a five-by-five crossbar at the same moment. An input may feed several outputs in one step.

Every input link lands in a small FIFO. The sequencer executes the step at the program counter as one indivisible unit. Nothing moves until every source named by the step holds a word and every destination named by the step is ready. When that holds, all moves fire in one cycle and the program counter advances. A flag bit in a step sends the counter back to entry 0, so a short loop can serve a stream indefinitely.

Back-pressure rules: an input word is taken on a cycle where `in_valid` and `in_ready` are both high. A word offered while `in_ready` is low is not stored, and the sender must offer it again. An output raises `out_valid` only when the step's sources are all present and every other output of the step is ready. A word offered on an output therefore may be withdrawn without transfer if a peer output of the same step drops its ready. Words leave the switch in the same cycle in which they are transferred.

Top module: `static_operand_switch`

## Requirements
- R1: After reset no output is valid and every input is ready. No output becomes valid before a cycle with `start` high, even if words are queued and the program is loaded. The first step runs from the cycle after `start`.
- R2: Port indices are N=0, S=1, E=2, W=3, P=4. A step word is 16 bits wide. Bits [3k+2:3k] select the source for output k, with code 0 meaning unused and code j+1 meaning input j. Bit 15 is the jump-to-0 flag.
- R3: Within a step there is no partial transfer. An output is valid only when all selected source FIFOs are non-empty and all other selected outputs are ready. No input is popped before the whole step completes.
- R4: An input selected by several outputs presents the same word on all of them and is popped exactly once.
- R5: When a step completes, the program counter moves to 0 if the jump flag is set, otherwise to the next entry (wrapping after the last). While the step stalls, the counter holds.
- R6: A program write is discarded if any field holds a code above 5 or selects the output's own port as source. The stored entry keeps its old contents.
- R7: Each input FIFO holds 4 words. `in_ready` is low exactly while 4 words are held, and a word offered then is dropped.
- R8: Words from one input leave the switch in the order they were accepted.
- R9: Each valid output carries the head word of the input its field selects, one word per output per cycle.
- R10: A step whose fields are all unused completes in one cycle with no output valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| prog_we | input | 1 | Program memory write strobe |
| prog_addr | input | 5 | Program entry written |
| prog_data | input | 16 | Step word written |
| start | input | 1 | Begins step execution |
| in_valid | input | 5 | Per-input word offered |
| in_ready | output | 5 | Per-input FIFO not full |
| in_data | input | 160 | Input words, port k at bits [32k+31:32k] |
| out_valid | output | 5 | Per-output word offered |
| out_ready | input | 5 | Per-output receiver ready |
| out_data | output | 160 | Output words, port k at bits [32k+31:32k] |

## Verification
The assertions assume three things about the inputs: reset is applied from time zero, `out_ready` is a defined level on every clock edge, and a sender does not count a word as delivered unless `in_ready` was high. The bench changes every input only at falling edges and loads each step before the sequencer can reach it. Steps are rewritten only at the entry where the counter is stalled, so a step is never changed between the cycle its sources are checked and the edge where it fires. Dropped words are tested by offering them on purpose while the FIFO is full, and then counting what comes out.

// File: rtl/sos_pkg.sv
package sos_pkg;
  localparam int NPORT   = 5;
  localparam int SEL_W   = 3;
  localparam int INSTR_W = NPORT * SEL_W + 1;
  localparam int JUMP_BIT = INSTR_W - 1;

  typedef enum logic [SEL_W-1:0] {
    SRC_NONE  = 3'd0,
    SRC_NORTH = 3'd1,
    SRC_SOUTH = 3'd2,
    SRC_EAST  = 3'd3,
    SRC_WEST  = 3'd4,
    SRC_PROC  = 3'd5
  } src_sel_e;
endpackage

// File: rtl/sos_fifo.sv
module sos_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  output logic             push_ready,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic             nonempty,
  output logic [CNT_W-1:0] level
);
  logic [W-1:0]     store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign push_ready = (level != CNT_W'(DEPTH));
  assign nonempty   = (level != '0);
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop && nonempty;
  assign head       = store[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      if (do_push && !do_pop)      level <= level + 1'b1;
      else if (do_pop && !do_push) level <= level - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/sos_sequencer.sv
module sos_sequencer
  import sos_pkg::*;
#(
  parameter int PROG_DEPTH = 32,
  localparam int PC_W = $clog2(PROG_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_we,
  input  logic [PC_W-1:0]    prog_addr,
  input  logic [INSTR_W-1:0] prog_data,
  input  logic               start,
  input  logic               step_done,
  output logic               running,
  output logic [PC_W-1:0]    pc,
  output logic [INSTR_W-1:0] instr
);
  logic [INSTR_W-1:0] prog_mem [PROG_DEPTH];
  logic               word_legal;

  always_comb begin
    word_legal = 1'b1;
    for (int k = 0; k < NPORT; k++) begin
      if (int'(prog_data[k*SEL_W +: SEL_W]) > NPORT) word_legal = 1'b0;
      if (int'(prog_data[k*SEL_W +: SEL_W]) == k + 1) word_legal = 1'b0;
    end
  end

  assign instr = prog_mem[pc];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PROG_DEPTH; i++) prog_mem[i] <= '0;
    end else if (prog_we && word_legal && (int'(prog_addr) < PROG_DEPTH)) begin
      prog_mem[prog_addr] <= prog_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      pc      <= '0;
    end else begin
      if (start) running <= 1'b1;
      if (running && step_done) begin
        if (instr[JUMP_BIT] || pc == PC_W'(PROG_DEPTH - 1)) pc <= '0;
        else                                                 pc <= pc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sos_crossbar.sv
module sos_crossbar
  import sos_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                    running,
  input  logic [NPORT*SEL_W-1:0]  fields,
  input  logic [NPORT-1:0]        src_nonempty,
  input  logic [NPORT*DATA_W-1:0] src_data,
  input  logic [NPORT-1:0]        dst_ready,
  output logic [NPORT-1:0]        dst_valid,
  output logic [NPORT*DATA_W-1:0] dst_data,
  output logic [NPORT-1:0]        src_pop,
  output logic                    step_done
);
  logic [NPORT-1:0] need_src;
  logic [NPORT-1:0] dst_used;
  logic [NPORT-1:0] dst_blocked;
  logic             srcs_present;

  always_comb begin
    need_src = '0;
    dst_used = '0;
    dst_data = '0;
    for (int k = 0; k < NPORT; k++) begin
      for (int j = 0; j < NPORT; j++) begin
        if (int'(fields[k*SEL_W +: SEL_W]) == j + 1) begin
          need_src[j] = 1'b1;
          dst_used[k] = 1'b1;
          dst_data[k*DATA_W +: DATA_W] = src_data[j*DATA_W +: DATA_W];
        end
      end
    end
  end

  assign dst_blocked  = dst_used & ~dst_ready;
  assign srcs_present = ((need_src & ~src_nonempty) == '0);
  assign step_done    = running && srcs_present && (dst_blocked == '0);
  assign src_pop      = step_done ? need_src : '0;

  for (genvar k = 0; k < NPORT; k++) begin : g_dst
    logic [NPORT-1:0] peer_mask;
    assign peer_mask    = ~(NPORT'(1) << k);
    assign dst_valid[k] = running && dst_used[k] && srcs_present &&
                          ((dst_blocked & peer_mask) == '0);
  end
endmodule

// File: rtl/static_operand_switch.sv
module static_operand_switch
  import sos_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int PROG_DEPTH = 32,
  parameter int FIFO_DEPTH = 4,
  localparam int PC_W  = $clog2(PROG_DEPTH),
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    prog_we,
  input  logic [PC_W-1:0]         prog_addr,
  input  logic [INSTR_W-1:0]      prog_data,
  input  logic                    start,
  input  logic [NPORT-1:0]        in_valid,
  output logic [NPORT-1:0]        in_ready,
  input  logic [NPORT*DATA_W-1:0] in_data,
  output logic [NPORT-1:0]        out_valid,
  input  logic [NPORT-1:0]        out_ready,
  output logic [NPORT*DATA_W-1:0] out_data
);
  logic [NPORT*DATA_W-1:0] head_flat;
  logic [NPORT-1:0]        nonempty;
  logic [NPORT-1:0]        pop;
  logic [NPORT*CNT_W-1:0]  levels;
  logic                    running;
  logic                    step_done;
  logic [PC_W-1:0]         pc;
  logic [INSTR_W-1:0]      instr;

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    sos_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_valid (in_valid[i]),
      .push_ready (in_ready[i]),
      .push_data  (in_data[i*DATA_W +: DATA_W]),
      .pop        (pop[i]),
      .head       (head_flat[i*DATA_W +: DATA_W]),
      .nonempty   (nonempty[i]),
      .level      (levels[i*CNT_W +: CNT_W])
    );
  end

  sos_sequencer #(.PROG_DEPTH(PROG_DEPTH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_we   (prog_we),
    .prog_addr (prog_addr),
    .prog_data (prog_data),
    .start     (start),
    .step_done (step_done),
    .running   (running),
    .pc        (pc),
    .instr     (instr)
  );

  sos_crossbar #(.DATA_W(DATA_W)) u_xbar (
    .running      (running),
    .fields       (instr[NPORT*SEL_W-1:0]),
    .src_nonempty (nonempty),
    .src_data     (head_flat),
    .dst_ready    (out_ready),
    .dst_valid    (out_valid),
    .dst_data     (out_data),
    .src_pop      (pop),
    .step_done    (step_done)
  );
endmodule

// File: rtl/sos_checker.sv
module sos_checker
  import sos_pkg::*;
#(
  parameter int PROG_DEPTH = 32,
  parameter int FIFO_DEPTH = 4,
  localparam int PC_W  = $clog2(PROG_DEPTH),
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   running,
  input logic                   step_done,
  input logic                   jump,
  input logic [PC_W-1:0]        pc,
  input logic [NPORT-1:0]       out_valid,
  input logic [NPORT-1:0]       out_ready,
  input logic [NPORT-1:0]       in_ready,
  input logic [NPORT-1:0]       pop,
  input logic [NPORT-1:0]       nonempty,
  input logic [NPORT*CNT_W-1:0] levels
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (out_valid == '0));

  assert_all_or_none_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(out_valid & ~out_ready)) |-> ((out_valid & out_ready) == '0));

  assert_pop_only_on_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop != '0) |-> step_done);

  assert_pop_has_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop & ~nonempty) == '0);

  assert_pc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !step_done) |=> $stable(pc));

  assert_pc_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && step_done && jump) |=> (pc == '0));

  assert_pc_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && step_done && !jump && pc != PC_W'(PROG_DEPTH - 1))
      |=> (pc == $past(pc) + 1'b1));

  for (genvar i = 0; i < NPORT; i++) begin : g_lvl
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      levels[i*CNT_W +: CNT_W] <= CNT_W'(FIFO_DEPTH));
    assert_ready_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready[i] |-> (levels[i*CNT_W +: CNT_W] == CNT_W'(FIFO_DEPTH)));
  end
endmodule

bind static_operand_switch sos_checker #(
  .PROG_DEPTH (PROG_DEPTH),
  .FIFO_DEPTH (FIFO_DEPTH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .running   (running),
  .step_done (step_done),
  .jump      (instr[sos_pkg::JUMP_BIT]),
  .pc        (pc),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .in_ready  (in_ready),
  .pop       (pop),
  .nonempty  (nonempty),
  .levels    (levels)
);

// File: tb/static_operand_switch_tb.sv
module static_operand_switch_tb;
  localparam int NP = 5;
  localparam int DW = 32;
  localparam int PN = 0, PS = 1, PE = 2, PW = 3, PP = 4;
  localparam logic [15:0] JMP = 16'h8000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            prog_we = 1'b0;
  logic [4:0]      prog_addr = '0;
  logic [15:0]     prog_data = '0;
  logic            start = 1'b0;
  logic [NP-1:0]   in_valid = '0;
  logic [NP-1:0]   in_ready;
  logic [NP*DW-1:0] in_data = '0;
  logic [NP-1:0]   out_valid;
  logic [NP-1:0]   out_ready = '1;
  logic [NP*DW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  static_operand_switch u_dut (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  // {source port, destination port, word}
  localparam logic [37:0] VEC [6] = '{
    {3'd0, 3'd1, 32'h1111_0001},
    {3'd1, 3'd0, 32'h2222_0002},
    {3'd2, 3'd4, 32'h3333_0003},
    {3'd3, 3'd2, 32'h4444_0004},
    {3'd4, 3'd3, 32'h5555_0005},
    {3'd4, 3'd0, 32'hA5A5_5A5A}
  };

  function automatic logic [15:0] route(input int dst, input int src);
    return 16'(src + 1) << (3 * dst);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic prog(input int addr, input logic [15:0] word);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = 5'(addr); prog_data = word;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic push(input int p, input logic [31:0] d);
    @(negedge clk);
    in_valid[p] = 1'b1; in_data[p*DW +: DW] = d;
    @(negedge clk);
    in_valid[p] = 1'b0;
    #1;
  endtask

  function automatic logic [31:0] od(input int p);
    return out_data[p*DW +: DW];
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(out_valid == '0, "R1 reset valid", 32'(out_valid), 0);
    chk(in_ready == 5'h1F, "R1 reset ready", 32'(in_ready), 32'h1F);
    rst_n = 1'b1;

    // R1: nothing moves before start
    prog(0, route(PE, PN) | JMP);
    push(PN, 32'hC0DE_0000);
    for (int i = 0; i < 3; i++) begin
      chk(out_valid == '0, "R1 idle before start", 32'(out_valid), 0);
      @(negedge clk);
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(out_valid == 5'b00100, "R1 first step after start", 32'(out_valid), 32'h4);
    chk(od(PE) == 32'hC0DE_0000, "R9 start word", od(PE), 32'hC0DE_0000);
    @(negedge clk); #1;
    chk(out_valid == '0, "R1 drained", 32'(out_valid), 0);

    // R2, R9: table of single routes
    for (int v = 0; v < 6; v++) begin
      int s, d;
      logic [31:0] w;
      s = int'(VEC[v][37:35]);
      d = int'(VEC[v][34:32]);
      w = VEC[v][31:0];
      prog(0, route(d, s) | JMP);
      push(s, w);
      chk(out_valid == 5'(1 << d), "R2 field decode", 32'(out_valid), 32'(1 << d));
      chk(od(d) == w, "R9 routed word", od(d), w);
      @(negedge clk); #1;
      chk(out_valid == '0, "R2 single transfer", 32'(out_valid), 0);
    end

    // R3: atomic step S<-N and E<-P
    prog(0, route(PS, PN) | route(PE, PP) | JMP);
    push(PN, 32'hAAAA_0001);
    chk(out_valid == '0, "R3 missing source", 32'(out_valid), 0);
    @(negedge clk); #1;
    chk(out_valid == '0, "R3 still waiting", 32'(out_valid), 0);
    out_ready[PE] = 1'b0;
    push(PP, 32'hBBBB_0002);
    chk(out_valid == 5'b00100, "R3 peer not ready", 32'(out_valid), 32'h4);
    @(negedge clk);
    out_ready[PE] = 1'b1;
    #1;
    chk(out_valid == 5'b00110, "R3 both fire", 32'(out_valid), 32'h6);
    chk(od(PS) == 32'hAAAA_0001, "R3 held word kept", od(PS), 32'hAAAA_0001);
    chk(od(PE) == 32'hBBBB_0002, "R9 proc word", od(PE), 32'hBBBB_0002);
    @(negedge clk); #1;
    chk(out_valid == '0, "R3 step done", 32'(out_valid), 0);

    // R4: multicast W -> N, S, P
    prog(0, route(PN, PW) | route(PS, PW) | route(PP, PW) | JMP);
    out_ready[PP] = 1'b0;
    push(PW, 32'hCAFE_0001);
    push(PW, 32'hCAFE_0002);
    chk(out_valid == 5'b10000, "R4 held by one dest", 32'(out_valid), 32'h10);
    @(negedge clk);
    out_ready[PP] = 1'b1;
    #1;
    chk(out_valid == 5'b10011, "R4 all dests", 32'(out_valid), 32'h13);
    chk(od(PN) == 32'hCAFE_0001 && od(PS) == 32'hCAFE_0001 && od(PP) == 32'hCAFE_0001,
        "R4 same word", od(PP), 32'hCAFE_0001);
    @(negedge clk); #1;
    chk(od(PN) == 32'hCAFE_0002 && od(PP) == 32'hCAFE_0002 && out_valid == 5'b10011,
        "R4 single pop", od(PN), 32'hCAFE_0002);
    @(negedge clk); #1;
    chk(out_valid == '0, "R4 drained", 32'(out_valid), 0);

    // R7, R8: fill E FIFO behind W output
    prog(0, route(PW, PE) | JMP);
    out_ready[PW] = 1'b0;
    for (int i = 0; i < 4; i++) push(PE, 32'hF000_0000 + 32'(i));
    chk(in_ready[PE] == 1'b0, "R7 full at four", 32'(in_ready), 32'h1B);
    push(PE, 32'hDEAD_DEAD);
    @(negedge clk);
    out_ready[PW] = 1'b1;
    #1;
    for (int i = 0; i < 4; i++) begin
      chk(out_valid[PW] && od(PW) == 32'hF000_0000 + 32'(i), "R8 order",
          od(PW), 32'hF000_0000 + 32'(i));
      @(negedge clk); #1;
    end
    chk(out_valid == '0, "R7 extra word dropped", 32'(out_valid), 0);
    chk(in_ready == 5'h1F, "R7 ready again", 32'(in_ready), 32'h1F);

    // R5, R10: three-step program
    prog(2, route(PW, PS) | JMP);
    prog(1, 16'h0000);
    prog(0, route(PE, PN));
    push(PS, 32'h0000_5001);
    chk(out_valid == '0, "R5 waits at step 0", 32'(out_valid), 0);
    push(PN, 32'h0000_4E01);
    chk(out_valid == 5'b00100 && od(PE) == 32'h0000_4E01, "R5 step 0", od(PE), 32'h0000_4E01);
    @(negedge clk); #1;
    chk(out_valid == '0, "R10 empty step", 32'(out_valid), 0);
    @(negedge clk); #1;
    chk(out_valid == 5'b01000 && od(PW) == 32'h0000_5001, "R5 step 2", od(PW), 32'h0000_5001);
    @(negedge clk); #1;
    chk(out_valid == '0, "R5 back at 0", 32'(out_valid), 0);
    push(PS, 32'h0000_5002);
    chk(out_valid == '0, "R5 jump to 0", 32'(out_valid), 0);

    // R6: illegal writes discarded
    prog(0, route(PE, PE) | JMP);
    prog(0, 16'h0006);
    push(PN, 32'h0000_4E02);
    chk(out_valid == 5'b00100 && od(PE) == 32'h0000_4E02, "R6 old step kept",
        32'(out_valid), 32'h4);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule